// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block performs one atomic memory operation at a time against a simple synchronous memory port. Each operation has a fixed length. A command is accepted while the block is idle. The block computes the effective address, issues a locked read, and forms the new value. It then issues a write under the same lock and finishes with a one-cycle completion pulse. That pulse carries the register writeback, if any.

The operation is chosen by an 8-bit opcode and by the low byte of a 32-bit immediate. Opcode 0xc3 selects a 32-bit access and opcode 0xdb selects a 64-bit access. The immediate selects one of these operations:
- add (0x00), or (0x40), and (0x50), xor (0xa0);
- fetching forms of the four above, which set bit 0x01 and return the old memory value into the source register;
- exchange (0xe1);
- compare-exchange against the accumulator register (0xf1), whose old memory value always goes back to the accumulator.

Any other command raises an illegal pulse and does not touch memory.

The memory returns read data on `mem_rdata` in the cycle after a read request. Writes take effect at the clock edge that ends the write request cycle.

Top module: `amo_seq`

## Requirements
- R1: After reset, `mem_req`, `mem_we`, `mem_lock`, `done`, `illegal`, `src_we` and `r0_we` are all low, and `busy` is low.
- R2: The read address and the write address of an operation both equal `base` plus `offset`, with `offset` sign-extended from 16 bits.
- R3: When `start` is sampled in the idle state, the read request appears in the following cycle. The write request appears two cycles after the read. `done` pulses in the cycle after the write, or two cycles after the read when no write is made. `mem_lock` stays high from the read request through the write request.
- R4: Immediate 0x00, 0x40, 0x50 and 0xa0 write memory with old+src, old|src, old&src and old^src respectively, with wrap-around. Neither register writeback enable is raised.
- R5: When immediate bit 0 is set on add, or, and or xor (0x01, 0x41, 0x51, 0xa1), memory is updated as in R4, and `src_we` pulses with `done` carrying the old memory value.
- R6: Immediate 0xe1 writes `src_val` to memory, and `src_we` returns the old memory value.
- R7: Immediate 0xf1 compares the old memory value with `r0_val`. It writes `src_val` only when they are equal. In both cases `r0_we` pulses with the old value and `src_we` stays low.
- R8: Opcode 0xc3 drives `mem_size` low. Only the low 32 bits of the read data, of `src_val` and of `r0_val` take part, the result wraps at 32 bits, and written data and returned values have their upper 32 bits zero. Opcode 0xdb drives `mem_size` high and works on all 64 bits.
- R9: An opcode other than 0xc3 or 0xdb, an immediate outside the ten listed codes, or any nonzero immediate bit above bit 7 raises `illegal` for one cycle, the cycle after `start`. No memory request and no `done` follow.
- R10: `start` is ignored while an operation is in progress (`busy` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command valid, sampled while idle |
| opcode | input | 8 | Operation opcode (0xc3 word, 0xdb double word) |
| imm | input | 32 | Operation selector |
| base | input | 64 | Destination base register value |
| offset | input | 16 | Signed address offset |
| src_val | input | 64 | Source register value |
| r0_val | input | 64 | Accumulator register value (compare operand) |
| busy | output | 1 | Operation in progress |
| illegal | output | 1 | One-cycle pulse for a rejected command |
| done | output | 1 | One-cycle completion pulse |
| src_we | output | 1 | Source register writeback enable (with done) |
| src_wdata | output | 64 | Source register writeback value |
| r0_we | output | 1 | Accumulator writeback enable (with done) |
| r0_wdata | output | 64 | Accumulator writeback value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_lock | output | 1 | Locked sequence in progress |
| mem_size | output | 1 | 1 for 64-bit access, 0 for 32-bit |
| mem_addr | output | 64 | Effective address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after a read request |

## Verification
A wrong sequencer state shows up at the memory port within one or two cycles. Typical symptoms are a write with no lock, a request two cycles late, or a missing or extra `done`. The bench times every request against `start`, so these are caught directly. A wrong operand latch or a missing 32-bit mask shows up only when the write data or the writeback value appears, three to four cycles after `start`. The vectors therefore put nonzero upper halves into the word cases, and include a compare that differs only in the upper word.

// File: rtl/amo_pkg.sv
// Shared types for the atomic read-modify-write sequencer.
// Assumes a single outstanding operation and fixed one-cycle read latency.
package amo_pkg;

    localparam logic [7:0] OPC_AMO_WORD  = 8'hc3;
    localparam logic [7:0] OPC_AMO_DWORD = 8'hdb;

    localparam logic [7:0] SEL_ADD   = 8'h00;
    localparam logic [7:0] SEL_OR    = 8'h40;
    localparam logic [7:0] SEL_AND   = 8'h50;
    localparam logic [7:0] SEL_XOR   = 8'ha0;
    localparam logic [7:0] SEL_XCHG  = 8'he1;
    localparam logic [7:0] SEL_CMPX  = 8'hf1;
    localparam logic [7:0] SEL_FETCH = 8'h01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_MODIFY,
        ST_WRITE,
        ST_DONE
    } amo_state_e;

    typedef enum logic [2:0] {
        K_ADD,
        K_OR,
        K_AND,
        K_XOR,
        K_XCHG,
        K_CMPX
    } amo_kind_e;

    typedef struct packed {
        amo_kind_e kind;
        logic      fetch;   // return old value into source register
        logic      dword;   // 64-bit access
    } amo_cmd_t;

endpackage

// File: rtl/amo_decode.sv
// Command decoder: classifies opcode and selector, flags unsupported forms.
// Assumes the operation selector lives in the low byte of the immediate
// and that all higher immediate bits must be zero.
module amo_decode
    import amo_pkg::*;
#(
    parameter int IMMW = 32
) (
    input  logic [7:0]      opcode,
    input  logic [IMMW-1:0] imm,
    output logic            legal,
    output amo_cmd_t        cmd
);

    logic       size_ok;
    logic       sel_ok;
    logic [7:0] sel;

    assign sel = imm[7:0];

    // Size check: only the word and double-word atomic opcodes are accepted.
    always_comb begin
        size_ok = (opcode == OPC_AMO_WORD) || (opcode == OPC_AMO_DWORD);
    end

    // Selector decode: map the low immediate byte to an operation kind.
    always_comb begin
        cmd.dword = (opcode == OPC_AMO_DWORD);
        cmd.fetch = 1'b0;
        cmd.kind  = K_ADD;
        sel_ok    = 1'b1;
        case (sel)
            SEL_ADD:             cmd.kind = K_ADD;
            SEL_ADD | SEL_FETCH: begin cmd.kind = K_ADD; cmd.fetch = 1'b1; end
            SEL_OR:              cmd.kind = K_OR;
            SEL_OR  | SEL_FETCH: begin cmd.kind = K_OR;  cmd.fetch = 1'b1; end
            SEL_AND:             cmd.kind = K_AND;
            SEL_AND | SEL_FETCH: begin cmd.kind = K_AND; cmd.fetch = 1'b1; end
            SEL_XOR:             cmd.kind = K_XOR;
            SEL_XOR | SEL_FETCH: begin cmd.kind = K_XOR; cmd.fetch = 1'b1; end
            SEL_XCHG:            begin cmd.kind = K_XCHG; cmd.fetch = 1'b1; end
            SEL_CMPX:            cmd.kind = K_CMPX;
            default:             sel_ok = 1'b0;
        endcase
    end

    // Legality: supported size, known selector, clean upper immediate.
    always_comb begin
        legal = size_ok && sel_ok && (imm[IMMW-1:8] == '0);
    end

endmodule

// File: rtl/amo_alu.sv
// Modify stage: forms the new memory value and the compare result.
// Assumes the old value and operands are already masked to the access size;
// the result is masked again so word operations wrap at 32 bits.
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  amo_cmd_t        cmd,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] r0,
    output logic [XLEN-1:0] new_val,
    output logic            cmp_hit
);

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] keep;

    // Lane mask: upper half kept only for double-word access.
    generate
        for (genvar g = 0; g < XLEN; g++) begin : g_keep
            if (g < HALF) begin : g_lo
                assign keep[g] = 1'b1;
            end else begin : g_hi
                assign keep[g] = cmd.dword;
            end
        end
    endgenerate

    // Operation select on full-width operands.
    always_comb begin
        case (cmd.kind)
            K_ADD:   raw = old_val + src;
            K_OR:    raw = old_val | src;
            K_AND:   raw = old_val & src;
            K_XOR:   raw = old_val ^ src;
            default: raw = src;           // exchange and compare-exchange
        endcase
    end

    // Result masking and compare against the accumulator.
    always_comb begin
        new_val = raw & keep;
        cmp_hit = (old_val == r0);
    end

endmodule

// File: rtl/amo_ctrl.sv
// Sequencer: idle -> read -> modify -> write -> done, write skipped on a
// compare miss. Rejected commands produce a one-cycle illegal pulse.
// Assumes read data is valid in the modify cycle.
module amo_ctrl
    import amo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       legal,
    input  logic       skip_write,
    output amo_state_e state,
    output logic       illegal
);

    amo_state_e nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:   if (start && legal) nxt = ST_READ;
            ST_READ:   nxt = ST_MODIFY;
            ST_MODIFY: nxt = skip_write ? ST_DONE : ST_WRITE;
            ST_WRITE:  nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Illegal pulse for a rejected command seen while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal <= 1'b0;
        else        illegal <= (state == ST_IDLE) && start && !legal;
    end

endmodule

// File: rtl/amo_seq.sv
// Atomic read-modify-write sequencer top. Latches the command at start,
// runs a locked read then optional write at base+offset, and reports the
// register writeback on a done pulse.
// Assumes a memory port with one-cycle read latency and no stall.
module amo_seq
    import amo_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int OFFW = 16,
    parameter int IMMW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [7:0]      opcode,
    input  logic [IMMW-1:0] imm,
    input  logic [XLEN-1:0] base,
    input  logic [OFFW-1:0] offset,
    input  logic [XLEN-1:0] src_val,
    input  logic [XLEN-1:0] r0_val,
    output logic            busy,
    output logic            illegal,
    output logic            done,
    output logic            src_we,
    output logic [XLEN-1:0] src_wdata,
    output logic            r0_we,
    output logic [XLEN-1:0] r0_wdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_lock,
    output logic            mem_size,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata
);

    localparam int HALF = XLEN / 2;

    amo_state_e      state;
    amo_cmd_t        dec_cmd;
    logic            dec_legal;
    amo_cmd_t        cmd_q;
    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] src_q;
    logic [XLEN-1:0] r0_q;
    logic [XLEN-1:0] old_q;
    logic [XLEN-1:0] new_q;
    logic [XLEN-1:0] rd_masked;
    logic [XLEN-1:0] alu_new;
    logic            alu_hit;
    logic            skip_write;
    logic            accept;

    amo_decode #(.IMMW(IMMW)) u_dec (
        .opcode (opcode),
        .imm    (imm),
        .legal  (dec_legal),
        .cmd    (dec_cmd)
    );

    amo_alu #(.XLEN(XLEN)) u_alu (
        .cmd     (cmd_q),
        .old_val (rd_masked),
        .src     (src_q),
        .r0      (r0_q),
        .new_val (alu_new),
        .cmp_hit (alu_hit)
    );

    amo_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .legal      (dec_legal),
        .skip_write (skip_write),
        .state      (state),
        .illegal    (illegal)
    );

    // Accept condition and size masking of returned read data.
    always_comb begin
        accept     = (state == ST_IDLE) && start && dec_legal;
        rd_masked  = cmd_q.dword ? mem_rdata : {{HALF{1'b0}}, mem_rdata[HALF-1:0]};
        skip_write = (cmd_q.kind == K_CMPX) && !alu_hit;
    end

    // Command and operand latch at acceptance, operands masked to size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '{kind: K_ADD, fetch: 1'b0, dword: 1'b0};
            addr_q <= '0;
            src_q  <= '0;
            r0_q   <= '0;
        end else if (accept) begin
            cmd_q  <= dec_cmd;
            addr_q <= base + {{(XLEN-OFFW){offset[OFFW-1]}}, offset};
            src_q  <= dec_cmd.dword ? src_val : {{HALF{1'b0}}, src_val[HALF-1:0]};
            r0_q   <= dec_cmd.dword ? r0_val  : {{HALF{1'b0}}, r0_val[HALF-1:0]};
        end
    end

    // Capture of old value and computed new value in the modify cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q <= '0;
            new_q <= '0;
        end else if (state == ST_MODIFY) begin
            old_q <= rd_masked;
            new_q <= alu_new;
        end
    end

    // Memory port and completion outputs decoded from the state.
    always_comb begin
        busy      = (state != ST_IDLE);
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_lock  = (state == ST_READ) || (state == ST_MODIFY) || (state == ST_WRITE);
        mem_size  = cmd_q.dword;
        mem_addr  = addr_q;
        mem_wdata = new_q;
        done      = (state == ST_DONE);
        src_we    = done && cmd_q.fetch;
        r0_we     = done && (cmd_q.kind == K_CMPX);
        src_wdata = old_q;
        r0_wdata  = old_q;
    end

endmodule

// File: rtl/amo_seq_chk.sv
// Property checker for the atomic sequencer, bound to every instance.
module amo_seq_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            illegal,
    input logic            done,
    input logic            src_we,
    input logic            r0_we,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_lock,
    input logic            mem_size,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata
);

    AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);                                        // R3

    AST_WRITE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_lock));                     // R3

    AST_DONE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock) |-> done);                                    // R3

    AST_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == $past(mem_addr, 2)));    // R2

    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_we || r0_we) |-> done);                                  // R5

    AST_WB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_we && r0_we));                                          // R7

    AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_size) |-> (mem_wdata[XLEN-1:XLEN/2] == '0)); // R8

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_req && !done && !mem_lock));                // R9

endmodule

bind amo_seq amo_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .illegal   (illegal),
    .done      (done),
    .src_we    (src_we),
    .r0_we     (r0_we),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_lock  (mem_lock),
    .mem_size  (mem_size),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/amo_seq_test.sv
module amo_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [7:0]  opcode;
    logic [31:0] imm;
    logic [63:0] base;
    logic [15:0] offset;
    logic [63:0] src_val;
    logic [63:0] r0_val;
    logic        busy, illegal, done, src_we, r0_we;
    logic [63:0] src_wdata, r0_wdata;
    logic        mem_req, mem_we, mem_lock, mem_size;
    logic [63:0] mem_addr, mem_wdata;
    logic [63:0] mem_rdata;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amo_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .imm(imm),
        .base(base), .offset(offset), .src_val(src_val), .r0_val(r0_val),
        .busy(busy), .illegal(illegal), .done(done),
        .src_we(src_we), .src_wdata(src_wdata), .r0_we(r0_we), .r0_wdata(r0_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: one location, read data one cycle after the request.
    logic [63:0] mem_init;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [63:0] wr_data, wr_addr, rd_addr;
    always @(posedge clk) begin
        if (mem_req && !mem_we) begin
            mem_rdata <= mem_init;
            rd_addr   <= mem_addr;
            rd_cnt    <= rd_cnt + 1;
        end
        if (mem_req && mem_we) begin
            wr_data <= mem_wdata;
            wr_addr <= mem_addr;
            wr_cnt  <= wr_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [7:0]  opc;
        logic [7:0]  sel;
        logic [63:0] src;
        logic [63:0] r0;
        logic [63:0] mem;
        logic        wr;
        logic [63:0] wdata;
        logic        swe;
        logic        rwe;
        logic [63:0] old;
        logic [63:0] size;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        // R4 add, 64-bit
        '{8'hdb, 8'h00, 64'h3, 64'h0, 64'h1000_0000_0000_0005, 1'b1, 64'h1000_0000_0000_0008, 1'b0, 1'b0, 64'h0, 64'h1},
        // R5 or with fetch
        '{8'hdb, 8'h41, 64'h0F, 64'h0, 64'hF0, 1'b1, 64'hFF, 1'b1, 1'b0, 64'hF0, 64'h1},
        // R4 and
        '{8'hdb, 8'h50, 64'h0F0F0F, 64'h0, 64'hFF00FF, 1'b1, 64'h0F000F, 1'b0, 1'b0, 64'h0, 64'h1},
        // R5 xor with fetch
        '{8'hdb, 8'ha1, 64'hFFFF, 64'h0, 64'hAAAA, 1'b1, 64'h5555, 1'b1, 1'b0, 64'hAAAA, 64'h1},
        // R8 word add with fetch, 32-bit wrap and zero extension
        '{8'hc3, 8'h01, 64'h1234_5678_0000_0002, 64'h0, 64'hDEAD_BEEF_FFFF_FFFF, 1'b1, 64'h1, 1'b1, 1'b0, 64'hFFFF_FFFF, 64'h0},
        // R6 exchange
        '{8'hdb, 8'he1, 64'h2222, 64'h0, 64'h1111, 1'b1, 64'h2222, 1'b1, 1'b0, 64'h1111, 64'h1},
        // R7 compare-exchange hit
        '{8'hdb, 8'hf1, 64'h77, 64'h55, 64'h55, 1'b1, 64'h77, 1'b0, 1'b1, 64'h55, 64'h1},
        // R7 compare-exchange miss
        '{8'hdb, 8'hf1, 64'h77, 64'h56, 64'h55, 1'b0, 64'h0, 1'b0, 1'b1, 64'h55, 64'h1},
        // R8 word compare-exchange hit with upper read bits set
        '{8'hc3, 8'hf1, 64'h9, 64'h8000_0000, 64'hFFFF_FFFF_8000_0000, 1'b1, 64'h9, 1'b0, 1'b1, 64'h8000_0000, 64'h0},
        // R8 word and, upper source ignored
        '{8'hc3, 8'h50, 64'hABCD_0000_00FF_00FF, 64'h0, 64'h1234_5678_FFFF_FFFF, 1'b1, 64'h00FF_00FF, 1'b0, 1'b0, 64'h0, 64'h0},
        // R4 64-bit add wrap
        '{8'hdb, 8'h00, 64'h2, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h1, 1'b0, 1'b0, 64'h0, 64'h1},
        // R8 word exchange
        '{8'hc3, 8'he1, 64'hFFFF_0000_AAAA_AAAA, 64'h0, 64'h7777_7777_0102_0304, 1'b1, 64'hAAAA_AAAA, 1'b1, 1'b0, 64'h0102_0304, 64'h0},
        // R7 R8 64-bit compare differing only in upper word misses
        '{8'hdb, 8'hf1, 64'h3, 64'h55, 64'h1_0000_0055, 1'b0, 64'h0, 1'b0, 1'b1, 64'h1_0000_0055, 64'h1}
    };

    // Results of the last operation, sampled at falling edges.
    int          rd_cyc, wr_cyc, done_cyc, ill_cyc, done_seen, size_seen;
    logic        got_swe, got_rwe;
    logic [63:0] got_swd, got_rwd;

    task automatic run_op(input logic [7:0] opc, input logic [31:0] im,
                          input logic [63:0] b, input logic [15:0] off,
                          input logic [63:0] s, input logic [63:0] r,
                          input logic [63:0] m);
        @(negedge clk);
        opcode = opc; imm = im; base = b; offset = off;
        src_val = s; r0_val = r; mem_init = m; start = 1'b1;
        rd_cyc = -1; wr_cyc = -1; done_cyc = -1; ill_cyc = -1; done_seen = 0;
        size_seen = -1;
        got_swe = 1'b0; got_rwe = 1'b0; got_swd = '0; got_rwd = '0;
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (mem_req && !mem_we) begin rd_cyc = c; size_seen = int'(mem_size); end
            if (mem_req && mem_we) wr_cyc = c;
            if (illegal) ill_cyc = c;
            if (done) begin
                done_cyc = c; done_seen++;
                got_swe = src_we; got_rwe = r0_we;
                got_swd = src_wdata; got_rwd = r0_wdata;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int rd0, wr0;
        rst_n = 1'b0; start = 1'b0; opcode = '0; imm = '0; base = '0;
        offset = '0; src_val = '0; r0_val = '0; mem_init = '0;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 mem_req", mem_req, 0);
        check("R1 mem_lock", mem_lock, 0);
        check("R1 done/illegal/busy", {done, illegal, busy, src_we, r0_we, mem_we}, 0);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            rd0 = rd_cnt; wr0 = wr_cnt;
            run_op(VECS[i].opc, {24'h0, VECS[i].sel}, 64'h8000, 16'hFFF8,
                   VECS[i].src, VECS[i].r0, VECS[i].mem);
            check("R3 read cycle", 64'(rd_cyc), 64'd1);
            check("R3 done cycle", 64'(done_cyc), VECS[i].wr ? 64'd4 : 64'd3);
            check("R3 single done", 64'(done_seen), 64'd1);
            check("R8 size", 64'(size_seen), VECS[i].size);
            check("R2 read address", rd_addr, 64'h7FF8);
            check("R7 write count", 64'(wr_cnt - wr0), {63'h0, VECS[i].wr});
            if (VECS[i].wr) begin
                check("R3 write cycle", 64'(wr_cyc), 64'd3);
                check("R4 write data", wr_data, VECS[i].wdata);
                check("R2 write address", wr_addr, 64'h7FF8);
            end
            check("R5 src_we", {63'h0, got_swe}, {63'h0, VECS[i].swe});
            check("R7 r0_we", {63'h0, got_rwe}, {63'h0, VECS[i].rwe});
            if (VECS[i].swe) check("R6 src writeback", got_swd, VECS[i].old);
            if (VECS[i].rwe) check("R7 r0 writeback", got_rwd, VECS[i].old);
        end

        // R2 positive offset
        run_op(8'hdb, 32'h00, 64'h1_0000, 16'h0123, 64'h1, 64'h0, 64'h5);
        check("R2 positive offset", wr_addr, 64'h1_0123);

        // R9 illegal forms: byte atomic, immediate-store class, bad selector, upper bits
        begin
            logic [7:0]  bad_opc [4] = '{8'hd3, 8'hc2, 8'hc3, 8'hdb};
            logic [31:0] bad_imm [4] = '{32'h0, 32'h0, 32'h02, 32'h100};
            for (int k = 0; k < 4; k++) begin
                rd0 = rd_cnt; wr0 = wr_cnt;
                run_op(bad_opc[k], bad_imm[k], 64'h40, 16'h0, 64'h1, 64'h1, 64'h7);
                check("R9 illegal cycle", 64'(ill_cyc), 64'd1);
                check("R9 no memory access", 64'((rd_cnt - rd0) + (wr_cnt - wr0)), 64'd0);
                check("R9 no done", 64'(done_seen), 64'd0);
            end
        end

        // R10 start held high while busy is ignored
        rd0 = rd_cnt;
        @(negedge clk);
        opcode = 8'hdb; imm = 32'h0; base = 64'h100; offset = 16'h0;
        src_val = 64'h1; r0_val = 64'h0; mem_init = 64'h10; start = 1'b1;
        @(negedge clk);
        check("R10 busy", {63'h0, busy}, 64'h1);
        imm = 32'he1; src_val = 64'h99;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        check("R10 one read only", 64'(rd_cnt - rd0), 64'd1);
        check("R10 first command kept", wr_data, 64'h11);
        check("R10 back to idle", {63'h0, busy}, 64'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule